// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block moves a multi-rank DDR2 memory (two ranks by default) into self-refresh and brings it back out. Two requests start entry: the end of a suspend-to-RAM power-down, or a software request. Before it lowers the clock enables, the block first switches off de-emphasis on the clock and command pins. It then waits until every bank reports idle. It issues the self-refresh entry command with all CKE pins low and holds the ranks in self-refresh. In that state the DRAM refreshes itself and the controller sends nothing.

There are two ways out. In the engine exit, all CKE pins rise and the block waits a programmable exit-to-command delay. It then issues one refresh to each rank in ascending rank order, separated by a programmable refresh cycle time, and returns to idle. In the register exit, software writes the per-rank CKE bits, which drive the pins directly. Once every bit is high the block returns to idle without issuing any refresh. A one-cycle done pulse marks the completion of entry and the completion of either exit.

Top module: `sr_refresh_seq`

## Requirements
- R1: After reset, all CKE outputs are high, `cmd` is NOP (2'b00), `deemph_en` is 1, and `in_sr` and `done` are 0.
- R2: A pulse on `s3_enter` or `sw_enter` while idle drops `deemph_en` in the next cycle. `deemph_en` stays low for at least two cycles before the self-refresh entry command appears.
- R3: The self-refresh entry command is issued only after `banks_idle` has been sampled high. While it is low, the block waits with all CKE high and `cmd` at NOP.
- R4: The entry command (`cmd` = 2'b01) lasts exactly one cycle with all CKE low. In the following cycle `in_sr` is 1, CKE stays low, `cmd` is NOP and `done` pulses for one cycle.
- R5: While in self-refresh, `cmd` stays NOP, and further entry requests change neither the CKE outputs nor `in_sr`.
- R6: A `sw_exit` pulse in self-refresh raises all CKE in the next cycle. The first refresh appears exactly max(`t_xsnr`,1)+1 cycles after that cycle.
- R7: An engine exit issues exactly one refresh (`cmd` = 2'b10) per rank, with `cmd_rank` counting up from 0. Consecutive refreshes start max(`t_rfc`,1)+1 cycles apart.
- R8: `done` pulses max(`t_rfc`,1)+1 cycles after the last refresh. In that cycle `deemph_en` returns to 1 and the block is idle again.
- R9: A `cke_wr` pulse in self-refresh copies `cke_wdata` onto the CKE pins in the next cycle. When the written value is all ones, the block leaves self-refresh in that same cycle with a `done` pulse and issues no refresh.
- R10: `cke_wr` and `sw_exit` outside self-refresh have no effect on CKE, `cmd`, `deemph_en` or `done`.
- R11: A timing input of zero behaves exactly like a value of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s3_enter | input | 1 | Suspend sequence finished; request self-refresh entry |
| sw_enter | input | 1 | Software request for self-refresh entry |
| sw_exit | input | 1 | Software request for engine exit with refreshes |
| cke_wr | input | 1 | Write strobe for the per-rank CKE bits |
| cke_wdata | input | NRANK | Per-rank CKE value written by software |
| banks_idle | input | 1 | All banks precharged |
| t_xsnr | input | TW | Cycles from CKE rise to first command |
| t_rfc | input | TW | Refresh cycle time in cycles |
| cke | output | NRANK | Per-rank clock enable |
| cmd | output | 2 | 00 NOP, 01 self-refresh entry, 10 refresh |
| cmd_rank | output | RW | Target rank of a refresh |
| deemph_en | output | 1 | De-emphasis enable for clock/command pins |
| in_sr | output | 1 | Ranks held in self-refresh |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every pair of exit delay and refresh time from 0 to 3 and compares each output cycle by cycle against a schedule computed arithmetically. An off-by-one in the wait counter, a missing zero clamp, or a rank counter that skips or repeats a rank shows up as a refresh in the wrong cycle or with the wrong rank. Entry is driven with the bank-idle input held low for a varying number of cycles. A design that does not wait would issue the entry command early, and one that restores de-emphasis too soon would show it high at the command. The register exit is tested with partial CKE writes, to show that the pins follow the written bits and that no refresh follows. Stray exits and CKE writes while idle are checked to leave the outputs unchanged.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEEMPH_OFF,
    ST_PRE_WAIT,
    ST_SRE,
    ST_IN_SR,
    ST_CKE_UP,
    ST_WAIT_XS,
    ST_REF,
    ST_WAIT_RFC
  } sr_state_e;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_SRE = 2'b01,
    CMD_REF = 2'b10
  } sr_cmd_e;

endpackage

// File: rtl/sr_wait_timer.sv
module sr_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R11: the counter never wraps below zero
  p_floor_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sr_cke_lanes.sv
module sr_cke_lanes #(
  parameter int NRANK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_low,
  input  logic             force_high,
  input  logic             wr_en,
  input  logic [NRANK-1:0] wr_data,
  output logic [NRANK-1:0] cke
);

  for (genvar r = 0; r < NRANK; r++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= 1'b1;
      end else if (force_low) begin
        lane_q <= 1'b0;
      end else if (force_high) begin
        lane_q <= 1'b1;
      end else if (wr_en) begin
        lane_q <= wr_data[r];
      end
    end
    assign cke[r] = lane_q;
  end

endmodule

// File: rtl/sr_ctrl_fsm.sv
module sr_ctrl_fsm
  import sr_pkg::*;
#(
  parameter int NRANK = 2,
  parameter int TW    = 8,
  parameter int RW    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_req,
  input  logic             sw_exit,
  input  logic             cke_wr,
  input  logic [NRANK-1:0] cke_wdata,
  input  logic             banks_idle,
  input  logic [TW-1:0]    t_xsnr,
  input  logic [TW-1:0]    t_rfc,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  output logic             cke_lo,
  output logic             cke_hi,
  output logic             cke_we,
  output logic [1:0]       cmd,
  output logic [RW-1:0]    cmd_rank,
  output logic             deemph_en,
  output logic             in_sr,
  output logic             done
);

  localparam logic [RW-1:0] LAST_RANK = RW'(NRANK - 1);

  sr_state_e     state_q, state_nxt;
  logic [RW-1:0] rank_q, rank_nxt;
  sr_cmd_e       cmd_q;
  logic [RW-1:0] rank_out_q;
  logic          deemph_q, in_sr_q, done_q;

  function automatic logic [TW-1:0] minus_one_clamped(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_comb begin
    state_nxt = state_q;
    rank_nxt  = rank_q;
    unique case (state_q)
      ST_IDLE:       if (enter_req) state_nxt = ST_DEEMPH_OFF;
      ST_DEEMPH_OFF: state_nxt = ST_PRE_WAIT;
      ST_PRE_WAIT:   if (banks_idle) state_nxt = ST_SRE;
      ST_SRE:        state_nxt = ST_IN_SR;
      ST_IN_SR: begin
        if (sw_exit) state_nxt = ST_CKE_UP;
        else if (cke_wr && (&cke_wdata)) state_nxt = ST_IDLE;
      end
      ST_CKE_UP: begin
        state_nxt = ST_WAIT_XS;
        rank_nxt  = '0;
      end
      ST_WAIT_XS:    if (tmr_expired) state_nxt = ST_REF;
      ST_REF:        state_nxt = ST_WAIT_RFC;
      ST_WAIT_RFC: begin
        if (tmr_expired) begin
          if (rank_q == LAST_RANK) begin
            state_nxt = ST_IDLE;
          end else begin
            state_nxt = ST_REF;
            rank_nxt  = rank_q + 1'b1;
          end
        end
      end
      default:       state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_q == ST_CKE_UP) || (state_q == ST_REF);
    tmr_val  = (state_q == ST_CKE_UP) ? minus_one_clamped(t_xsnr)
                                      : minus_one_clamped(t_rfc);
    cke_lo   = (state_nxt == ST_SRE);
    cke_hi   = (state_nxt != ST_SRE) && (state_nxt != ST_IN_SR);
    cke_we   = (state_q == ST_IN_SR) && cke_wr && !sw_exit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      rank_q     <= '0;
      cmd_q      <= CMD_NOP;
      rank_out_q <= '0;
      deemph_q   <= 1'b1;
      in_sr_q    <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_nxt;
      rank_q     <= rank_nxt;
      cmd_q      <= (state_nxt == ST_SRE) ? CMD_SRE :
                    (state_nxt == ST_REF) ? CMD_REF : CMD_NOP;
      rank_out_q <= rank_nxt;
      deemph_q   <= (state_nxt == ST_IDLE);
      in_sr_q    <= (state_nxt == ST_IN_SR);
      done_q     <= ((state_q == ST_SRE) && (state_nxt == ST_IN_SR)) ||
                    ((state_q != ST_IDLE) && (state_nxt == ST_IDLE));
    end
  end

  assign cmd       = cmd_q;
  assign cmd_rank  = rank_out_q;
  assign deemph_en = deemph_q;
  assign in_sr     = in_sr_q;
  assign done      = done_q;

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a refresh is never issued while ranks are in self-refresh
  p_ref_not_in_sr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF) |-> !in_sr_q);

endmodule

// File: rtl/sr_refresh_seq.sv
module sr_refresh_seq
  import sr_pkg::*;
#(
  parameter int  NRANK = 2,
  parameter int  TW    = 8,
  localparam int RW    = (NRANK > 1) ? $clog2(NRANK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s3_enter,
  input  logic             sw_enter,
  input  logic             sw_exit,
  input  logic             cke_wr,
  input  logic [NRANK-1:0] cke_wdata,
  input  logic             banks_idle,
  input  logic [TW-1:0]    t_xsnr,
  input  logic [TW-1:0]    t_rfc,
  output logic [NRANK-1:0] cke,
  output logic [1:0]       cmd,
  output logic [RW-1:0]    cmd_rank,
  output logic             deemph_en,
  output logic             in_sr,
  output logic             done
);

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          cke_lo, cke_hi, cke_we;

  sr_ctrl_fsm #(.NRANK(NRANK), .TW(TW), .RW(RW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enter_req  (s3_enter | sw_enter),
    .sw_exit    (sw_exit),
    .cke_wr     (cke_wr),
    .cke_wdata  (cke_wdata),
    .banks_idle (banks_idle),
    .t_xsnr     (t_xsnr),
    .t_rfc      (t_rfc),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cke_lo     (cke_lo),
    .cke_hi     (cke_hi),
    .cke_we     (cke_we),
    .cmd        (cmd),
    .cmd_rank   (cmd_rank),
    .deemph_en  (deemph_en),
    .in_sr      (in_sr),
    .done       (done)
  );

  sr_wait_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sr_cke_lanes #(.NRANK(NRANK)) u_cke (
    .clk       (clk),
    .rst       (rst),
    .force_low (cke_lo),
    .force_high(cke_hi),
    .wr_en     (cke_we),
    .wr_data   (cke_wdata),
    .cke       (cke)
  );

  // R4: entry command goes out with every CKE low
  p_sre_cke_low_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRE) |-> (cke == '0));

  // R2: de-emphasis already off for two cycles at the entry command
  p_deemph_off_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRE) |-> (!deemph_en && !$past(deemph_en)));

  // R3: entry command only after the banks reported idle
  p_banks_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SRE) |-> $past(banks_idle));

  // R5: nothing but NOP while in self-refresh
  p_quiet_in_sr_r5: assert property (@(posedge clk) disable iff (rst)
    in_sr |-> (cmd == CMD_NOP));

  // R6: a refresh requires every CKE high
  p_ref_cke_high_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> (&cke));

endmodule

// File: tb/sim_sr_refresh_seq.sv
module sim_sr_refresh_seq;

  localparam int NRANK = 2;
  localparam int TW    = 8;

  logic clk = 1'b0;
  logic rst;
  logic s3_enter, sw_enter, sw_exit, cke_wr, banks_idle;
  logic [NRANK-1:0] cke_wdata;
  logic [TW-1:0] t_xsnr, t_rfc;
  logic [NRANK-1:0] cke;
  logic [1:0] cmd;
  logic [0:0] cmd_rank;
  logic deemph_en, in_sr, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sr_refresh_seq #(.NRANK(NRANK), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .s3_enter(s3_enter), .sw_enter(sw_enter),
    .sw_exit(sw_exit), .cke_wr(cke_wr), .cke_wdata(cke_wdata),
    .banks_idle(banks_idle), .t_xsnr(t_xsnr), .t_rfc(t_rfc),
    .cke(cke), .cmd(cmd), .cmd_rank(cmd_rank), .deemph_en(deemph_en),
    .in_sr(in_sr), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_inputs();
    s3_enter = 0; sw_enter = 0; sw_exit = 0; cke_wr = 0;
  endtask

  task automatic do_entry(input bit use_s3, input int busy);
    @(negedge clk);
    banks_idle = 0;
    if (use_s3) s3_enter = 1; else sw_enter = 1;
    step();
    clear_inputs();
    check("R2", "deemph after request", deemph_en, 0);
    check("R2", "cke after request", cke, 3);
    for (int i = 0; i < busy + 1; i++) begin
      step();
      check("R3", "cmd while banks busy", cmd, 0);
      check("R3", "cke while banks busy", cke, 3);
      check("R2", "deemph while waiting", deemph_en, 0);
    end
    @(negedge clk);
    banks_idle = 1;
    step();
    check("R4", "entry cmd", cmd, 1);
    check("R4", "cke at entry", cke, 0);
    check("R2", "deemph at entry", deemph_en, 0);
    step();
    check("R4", "cmd after entry", cmd, 0);
    check("R4", "in_sr after entry", in_sr, 1);
    check("R4", "done after entry", done, 1);
    check("R4", "cke in sr", cke, 0);
    step();
    check("R4", "done single pulse", done, 0);
    check("R5", "in_sr held", in_sr, 1);
  endtask

  task automatic do_exit(input int tx, input int tr);
    int x, r, ref0, ref1, fin;
    x = (tx == 0) ? 1 : tx;
    r = (tr == 0) ? 1 : tr;
    ref0 = x + 1;
    ref1 = ref0 + r + 1;
    fin  = ref1 + r + 1;
    @(negedge clk);
    t_xsnr = TW'(tx);
    t_rfc  = TW'(tr);
    sw_exit = 1;
    step();
    clear_inputs();
    for (int c = 0; c <= fin + 1; c++) begin
      if (c > 0) step();
      check("R6", "cke during exit", cke, 3);
      if (c == ref0) begin
        check("R6", "first refresh", cmd, 2);
        check("R7", "rank of first refresh", cmd_rank, 0);
      end else if (c == ref1) begin
        check("R7", "second refresh", cmd, 2);
        check("R7", "rank of second refresh", cmd_rank, 1);
      end else begin
        check((tx == 0 || tr == 0) ? "R11" : "R7", "no refresh", cmd, 0);
      end
      check("R8", "done timing", done, (c == fin) ? 1 : 0);
      check("R8", "deemph restore", deemph_en, (c >= fin) ? 1 : 0);
      check("R8", "in_sr clear", in_sr, 0);
    end
  endtask

  initial begin
    clear_inputs();
    cke_wdata = '0; banks_idle = 1; t_xsnr = 8'd2; t_rfc = 8'd2;
    rst = 1;
    repeat (4) step();
    @(negedge clk);
    rst = 0;
    step();
    check("R1", "cke", cke, 3);
    check("R1", "cmd", cmd, 0);
    check("R1", "deemph", deemph_en, 1);
    check("R1", "in_sr", in_sr, 0);
    check("R1", "done", done, 0);

    // R10: stray CKE write and exit while idle
    @(negedge clk);
    cke_wr = 1; cke_wdata = 2'b00;
    step();
    clear_inputs();
    check("R10", "cke after idle write", cke, 3);
    check("R10", "done after idle write", done, 0);
    @(negedge clk);
    sw_exit = 1;
    step();
    clear_inputs();
    for (int i = 0; i < 8; i++) begin
      check("R10", "cmd after idle exit", cmd, 0);
      check("R10", "deemph after idle exit", deemph_en, 1);
      check("R10", "done after idle exit", done, 0);
      step();
    end

    // R6 R7 R8 R11: sweep of timing pairs
    for (int tx = 0; tx < 4; tx++) begin
      for (int tr = 0; tr < 4; tr++) begin
        do_entry(((tx + tr) % 2) == 1, (tx + tr) % 3);
        @(negedge clk);
        sw_enter = 1; s3_enter = 1;
        step();
        clear_inputs();
        check("R5", "cke after repeat entry", cke, 0);
        check("R5", "in_sr after repeat entry", in_sr, 1);
        check("R5", "cmd after repeat entry", cmd, 0);
        step();
        check("R5", "in_sr still", in_sr, 1);
        do_exit(tx, tr);
      end
    end

    // R9: register exit with partial writes
    do_entry(1'b0, 1);
    @(negedge clk);
    cke_wr = 1; cke_wdata = 2'b01;
    step();
    clear_inputs();
    check("R9", "cke rank0 up", cke, 1);
    check("R9", "still in sr", in_sr, 1);
    check("R9", "no done on partial", done, 0);
    @(negedge clk);
    cke_wr = 1; cke_wdata = 2'b10;
    step();
    clear_inputs();
    check("R9", "cke follows write", cke, 2);
    check("R9", "cmd quiet", cmd, 0);
    @(negedge clk);
    cke_wr = 1; cke_wdata = 2'b11;
    step();
    clear_inputs();
    check("R9", "cke all up", cke, 3);
    check("R9", "done on full write", done, 1);
    check("R9", "left sr", in_sr, 0);
    check("R9", "deemph back", deemph_en, 1);
    for (int i = 0; i < 20; i++) begin
      step();
      check("R9", "no refresh after register exit", cmd, 0);
      check("R9", "no second done", done, 0);
    end
    @(negedge clk);
    cke_wr = 1; cke_wdata = 2'b00;
    step();
    clear_inputs();
    check("R10", "cke after post-exit write", cke, 3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule